// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Controller

This block drives a three-wire serial configuration EEPROM. The EEPROM has a chip select, a shift clock, a data line into the memory and a data line out of it. The controller runs three kinds of transaction on these lines: read, write-enable and write. Each serial bit takes two ticks of an internal divider. One tick drives the data-in line with the shift clock low. The next tick raises the shift clock.

Right after reset the controller loads the whole image on its own. First it works out how wide the device's address field is. It does this by reading location 0 with a 6-bit address: an all-ones result selects the 8-bit width. It then reads every word, adds them up, and checks the 16-bit total against a fixed signature. The first three words give the 48-bit station address. Once loading ends, `ready` rises.

After that a host can issue single reads, write-enables and writes. It uses a one-cycle request with an opcode, an address and write data. The host waits for `busy` to fall. A one-cycle `done` returns the read data and an error flag.

Top module: `seeprom_ctrl`

## Requirements
- R1: Each serial frame starts with a 1 bit, then a two-bit opcode, then the address, all most significant bit first. The opcode is 10 for read, 01 for write and 00 for write-enable, and a write-enable carries an all-ones address. `ee_di` changes only while `ee_sclk` is low, and the EEPROM samples it on the rising edge of `ee_sclk`.
- R2: At start-up, location 0 is read with 6 address bits. A result of 16'hFFFF sets `addr_wide` to 1, which selects 8 address bits for all later frames. Any other result sets `addr_wide` to 0, which selects 6 address bits.
- R3: Host opcode 00 or 11 is a read. The frame is followed by 16 shift clocks, and `ee_do` is sampled at each rising edge, first bit into bit 15. The word appears on `rdata` with `done`, and `err` is 0.
- R4: Host opcode 01 is a write. The 16 data bits follow the address, MSB first. `ee_cs` then goes low for one tick and high again. The write completes with `err`=0 once `ee_do` reads 1, and the new value can then be read back.
- R5: If `ee_do` stays 0 for TMO_TICKS ticks while the controller waits for a write to finish, the write ends with `err`=1.
- R6: If the 16-bit sum of all WORDS words equals 16'hBABA, `sum_bad` is 0. In that case `station` is {w0[7:0], w0[15:8], w1[7:0], w1[15:8], w2[7:0], w2[15:8]}, with the first byte in bits 47:40. `station` does not change after `ready` rises.
- R7: If the sum differs from 16'hBABA, `sum_bad` is 1 and `station` is all zeros.
- R8: Between two transactions, `ee_cs` stays low for at least DIV clock cycles.
- R9: A write request (opcode 01) made before any write-enable (opcode 10) has completed since reset is rejected. It finishes with `err`=1 and produces no chip-select activity.
- R10: `busy` is 1 from reset until loading ends. It is also 1 from the cycle after a request is accepted until `done`. A request made while `busy` is 1 is ignored.
- R11: `ee_sclk` is low whenever `ee_cs` is low.
- R12: `done` is a single-cycle pulse, and there is exactly one `done` per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sclk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data and ready flag from the EEPROM |
| req | input | 1 | Host request strobe |
| req_op | input | 2 | 00/11 read, 01 write, 10 write-enable |
| req_addr | input | 8 | Word address (bits 7:6 unused at 6-bit width) |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Load or host request in progress |
| done | output | 1 | Request completed (one cycle) |
| err | output | 1 | Completed request failed |
| rdata | output | 16 | Last word read |
| ready | output | 1 | Start-up load finished |
| addr_wide | output | 1 | 1 when 8 address bits are in use |
| sum_bad | output | 1 | Image checksum mismatch |
| station | output | 48 | Station address from words 0 to 2 |

## Verification
The bench builds the controller with DIV=2 and TMO_TICKS=64, so a full 65-word load takes only a few thousand cycles. With those values, a memory model whose programming delay is shorter than the poll window completes writes, while a stuck model reaches the timeout path. Two instances are built. One faces a 6-bit memory holding a valid image. The other faces an 8-bit memory whose word 0 is all ones and whose checksum is wrong. Between them they exercise both results of the width probe and both results of the checksum, including 8-bit addressing above location 63.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

  localparam logic [15:0] IMAGE_SUM = 16'hBABA;

  typedef enum logic [1:0] {
    SOP_WREN  = 2'b00,
    SOP_WRITE = 2'b01,
    SOP_READ  = 2'b10
  } sop_t;

  // Serial frame, left aligned: start bit, opcode, address, optional data.
  function automatic logic [26:0] frame_bits(sop_t op, logic [7:0] addr,
                                             logic wide, logic [15:0] wd);
    if (wide) return {1'b1, op, addr, wd};
    return {1'b1, op, addr[5:0], wd, 2'b00};
  endfunction

  function automatic logic [4:0] frame_len(sop_t op, logic wide);
    logic [4:0] n;
    n = wide ? 5'd11 : 5'd9;
    if (op == SOP_WRITE) n = n + 5'd16;
    return n;
  endfunction

  // Low byte of each word goes out first.
  function automatic logic [47:0] station_addr(logic [15:0] a, logic [15:0] b,
                                               logic [15:0] c);
    return {a[7:0], a[15:8], b[7:0], b[15:8], c[7:0], c[15:8]};
  endfunction

endpackage

// File: rtl/seeprom_tick.sv
module seeprom_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/seeprom_phy.sv
module seeprom_phy
  import seeprom_pkg::*;
#(
  parameter int DIV       = 4,
  parameter int TMO_TICKS = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        start,
  input  sop_t        op,
  input  logic [7:0]  addr,
  input  logic        wide,
  input  logic [15:0] wdata,
  output logic        cs,
  output logic        sclk,
  output logic        di,
  input  logic        dout,
  output logic        done,
  output logic        tmo,
  output logic [15:0] rdata
);
  localparam int TW = $clog2(TMO_TICKS + 1);
  localparam int LW = $clog2(DIV + 1);

  typedef enum logic [2:0] {P_IDLE, P_GAP, P_SHIFT, P_RDIN, P_DROP, P_POLL, P_END} pst_t;

  pst_t          st;
  sop_t          cur;
  logic [26:0]   sh;
  logic [4:0]    left;
  logic [TW-1:0] wait_cnt;
  logic          fail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= P_IDLE; cur <= SOP_READ; sh <= '0; left <= '0; wait_cnt <= '0;
      fail <= 1'b0; cs <= 1'b0; sclk <= 1'b0; di <= 1'b0;
      done <= 1'b0; tmo <= 1'b0; rdata <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        P_IDLE: if (start) begin
          cur  <= op;
          sh   <= frame_bits(op, addr, wide, wdata);
          left <= frame_len(op, wide);
          fail <= 1'b0;
          st   <= P_GAP;
        end
        P_GAP: if (tick) begin
          cs <= 1'b1; sclk <= 1'b0; di <= sh[26]; st <= P_SHIFT;
        end
        P_SHIFT: if (tick) begin
          if (!sclk) sclk <= 1'b1;
          else begin
            sclk <= 1'b0;
            if (left == 5'd1) begin
              di   <= 1'b0;
              left <= 5'd16;
              case (cur)
                SOP_READ:  st <= P_RDIN;
                SOP_WRITE: begin cs <= 1'b0; st <= P_DROP; end
                default:   begin cs <= 1'b0; st <= P_END; end
              endcase
            end else begin
              left <= left - 1'b1;
              sh   <= {sh[25:0], 1'b0};
              di   <= sh[25];
            end
          end
        end
        P_RDIN: if (tick) begin
          if (!sclk) begin
            sclk  <= 1'b1;
            rdata <= {rdata[14:0], dout};
          end else begin
            sclk <= 1'b0;
            if (left == 5'd1) begin cs <= 1'b0; st <= P_END; end
            else left <= left - 1'b1;
          end
        end
        P_DROP: if (tick) begin
          cs <= 1'b1; wait_cnt <= '0; st <= P_POLL;
        end
        P_POLL: if (tick) begin
          if (dout) begin cs <= 1'b0; st <= P_END; end
          else if (wait_cnt == TW'(TMO_TICKS - 1)) begin
            cs <= 1'b0; fail <= 1'b1; st <= P_END;
          end else wait_cnt <= wait_cnt + 1'b1;
        end
        P_END: if (tick) begin
          st <= P_IDLE; done <= 1'b1; tmo <= fail;
        end
        default: st <= P_IDLE;
      endcase
    end
  end

  // Clocks spent with chip select low, saturating; reset counts as a long gap.
  logic [LW-1:0] low_clks;
  always_ff @(posedge clk) begin
    if (!rst_n) low_clks <= LW'(DIV);
    else if (cs) low_clks <= '0;
    else if (low_clks != LW'(DIV)) low_clks <= low_clks + 1'b1;
  end

  a_r8_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs) |-> (low_clks >= LW'(DIV)));
  a_r11_sclk_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !sclk);
  a_r1_di_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(di));
  a_r5_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == P_POLL) |-> (wait_cnt < TW'(TMO_TICKS)));
endmodule

// File: rtl/seeprom_ctrl.sv
module seeprom_ctrl
  import seeprom_pkg::*;
#(
  parameter int DIV       = 50,
  parameter int TMO_TICKS = 100000,
  parameter int WORDS     = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        ee_cs,
  output logic        ee_sclk,
  output logic        ee_di,
  input  logic        ee_do,
  input  logic        req,
  input  logic [1:0]  req_op,
  input  logic [7:0]  req_addr,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [15:0] rdata,
  output logic        ready,
  output logic        addr_wide,
  output logic        sum_bad,
  output logic [47:0] station
);
  localparam int IW = $clog2(WORDS);

  typedef enum logic [2:0] {T_PROBE, T_PWAIT, T_LOAD, T_LWAIT, T_READY, T_HWAIT, T_REJ} tst_t;

  tst_t          st;
  logic [IW-1:0] widx;
  logic [15:0]   sum, w0, w1, w2;
  logic          wen_seen;
  sop_t          hop_q;

  logic          tick, ph_start, ph_done, ph_tmo;
  sop_t          hsop, ph_op;
  logic [7:0]    ph_addr;
  logic [15:0]   ph_rdata;

  // Host opcode decode: 01 write, 10 write-enable, anything else read.
  always_comb begin
    case (req_op)
      2'b01:   hsop = SOP_WRITE;
      2'b10:   hsop = SOP_WREN;
      default: hsop = SOP_READ;
    endcase
  end

  assign ph_start = (st == T_PROBE) || (st == T_LOAD) ||
                    ((st == T_READY) && req && !((hsop == SOP_WRITE) && !wen_seen));
  assign ph_op    = (st == T_READY) ? hsop : SOP_READ;
  assign ph_addr  = (st == T_READY) ? ((hsop == SOP_WREN) ? 8'hFF : req_addr)
                  : (st == T_LOAD)  ? 8'(widx) : 8'h00;
  assign busy     = (st != T_READY);

  seeprom_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  seeprom_phy #(.DIV(DIV), .TMO_TICKS(TMO_TICKS)) u_phy (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(ph_start), .op(ph_op),
    .addr(ph_addr), .wide(addr_wide), .wdata(req_wdata),
    .cs(ee_cs), .sclk(ee_sclk), .di(ee_di), .dout(ee_do),
    .done(ph_done), .tmo(ph_tmo), .rdata(ph_rdata));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= T_PROBE; widx <= '0; sum <= '0; w0 <= '0; w1 <= '0; w2 <= '0;
      wen_seen <= 1'b0; hop_q <= SOP_READ; done <= 1'b0; err <= 1'b0;
      rdata <= '0; ready <= 1'b0; addr_wide <= 1'b0; sum_bad <= 1'b0;
      station <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        T_PROBE: st <= T_PWAIT;
        T_PWAIT: if (ph_done) begin
          addr_wide <= (ph_rdata == 16'hFFFF);
          st        <= T_LOAD;
        end
        T_LOAD: st <= T_LWAIT;
        T_LWAIT: if (ph_done) begin
          sum <= sum + ph_rdata;
          if (widx == IW'(0)) w0 <= ph_rdata;
          if (widx == IW'(1)) w1 <= ph_rdata;
          if (widx == IW'(2)) w2 <= ph_rdata;
          if (widx == IW'(WORDS - 1)) begin
            ready <= 1'b1;
            st    <= T_READY;
            if (16'(sum + ph_rdata) == IMAGE_SUM) station <= station_addr(w0, w1, w2);
            else sum_bad <= 1'b1;
          end else begin
            widx <= widx + 1'b1;
            st   <= T_LOAD;
          end
        end
        T_READY: if (req) begin
          hop_q <= hsop;
          st    <= ((hsop == SOP_WRITE) && !wen_seen) ? T_REJ : T_HWAIT;
        end
        T_HWAIT: if (ph_done) begin
          done <= 1'b1;
          err  <= ph_tmo;
          if (hop_q == SOP_READ) rdata <= ph_rdata;
          if (hop_q == SOP_WREN) wen_seen <= 1'b1;
          st   <= T_READY;
        end
        T_REJ: begin
          done <= 1'b1; err <= 1'b1; st <= T_READY;
        end
        default: st <= T_PROBE;
      endcase
    end
  end

  a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> busy);
  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_start && (ph_op == SOP_WRITE)) |-> wen_seen);
  a_r7_zero_station: assert property (@(posedge clk) disable iff (!rst_n)
    sum_bad |-> (station == 48'd0));
  a_r6_station_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ready) && ready) |-> $stable(station));
endmodule

// File: tb/test_seeprom_ctrl.sv
module eeprom_model #(
  parameter int AWM = 6
) (
  input  logic cs,
  input  logic sclk,
  input  logic di,
  output logic dout
);
  logic [15:0] mem [0:(1<<AWM)-1];
  logic [15:0] rword, wword;
  logic [31:0] shreg;
  logic [AWM-1:0] a;
  logic [1:0]  opc;
  logic        stuck, wen, pend, poll, pbusy, rd_act;
  int          cnt, ph;

  initial begin
    stuck = 0; wen = 0; pend = 0; poll = 0; pbusy = 0; rd_act = 0;
    ph = 0; cnt = 0; shreg = 0; rword = 0; wword = 0; a = '0; opc = 0;
  end

  assign dout = poll ? !(pbusy || stuck) : (rd_act ? rword[15] : 1'b1);

  always @(posedge pbusy) begin
    #200ns;
    pbusy = 0;
  end

  always @(posedge cs) begin
    cnt = 0; shreg = 0; ph = 0; rd_act = 0;
    if (pend) begin pend = 0; poll = 1; pbusy = 1; end
    else poll = 0;
  end

  always @(negedge cs) begin
    if (ph == 3 && wen) begin mem[a] = wword; pend = 1; end
    ph = 0; rd_act = 0; poll = 0;
  end

  always @(posedge sclk) begin
    if (cs) begin
      case (ph)
        0: begin
          shreg = {shreg[30:0], di};
          cnt++;
          if (cnt == 3 + AWM) begin
            a   = shreg[AWM-1:0];
            opc = shreg[AWM+1:AWM];
            if (!shreg[AWM+2]) ph = 4;
            else if (opc == 2'b10) begin rword = mem[a]; rd_act = 1; ph = 1; end
            else if (opc == 2'b01) begin ph = 2; cnt = 0; end
            else begin
              if (opc == 2'b00 && (&shreg[AWM-1:0])) wen = 1;
              ph = 4;
            end
          end
        end
        1: rword = {rword[14:0], 1'b1};
        2: begin
          wword = {wword[14:0], di};
          cnt++;
          if (cnt == 16) ph = 3;
        end
        default: ;
      endcase
    end
  end
endmodule

module test_seeprom_ctrl;
  localparam int DIV = 2;
  localparam int TMO = 64;

  logic clk = 0;
  logic rst_n = 0;
  always #2ns clk = ~clk;

  // Instance A: 6-bit memory, valid image
  logic        cs_a, sclk_a, di_a, do_a, req_a, busy_a, done_a, err_a, ready_a, wide_a, bad_a;
  logic [1:0]  op_a;
  logic [7:0]  addr_a;
  logic [15:0] wd_a, rd_a;
  logic [47:0] st_a;
  // Instance B: 8-bit memory, corrupt image
  logic        cs_b, sclk_b, di_b, do_b, req_b, busy_b, done_b, err_b, ready_b, wide_b, bad_b;
  logic [1:0]  op_b;
  logic [7:0]  addr_b;
  logic [15:0] wd_b, rd_b;
  logic [47:0] st_b;

  seeprom_ctrl #(.DIV(DIV), .TMO_TICKS(TMO), .WORDS(64)) i_seeprom_ctrl (
    .clk(clk), .rst_n(rst_n), .ee_cs(cs_a), .ee_sclk(sclk_a), .ee_di(di_a), .ee_do(do_a),
    .req(req_a), .req_op(op_a), .req_addr(addr_a), .req_wdata(wd_a),
    .busy(busy_a), .done(done_a), .err(err_a), .rdata(rd_a),
    .ready(ready_a), .addr_wide(wide_a), .sum_bad(bad_a), .station(st_a));
  eeprom_model #(.AWM(6)) i_mdl_a (.cs(cs_a), .sclk(sclk_a), .di(di_a), .dout(do_a));

  seeprom_ctrl #(.DIV(DIV), .TMO_TICKS(TMO), .WORDS(64)) i_seeprom_ctrl_wide (
    .clk(clk), .rst_n(rst_n), .ee_cs(cs_b), .ee_sclk(sclk_b), .ee_di(di_b), .ee_do(do_b),
    .req(req_b), .req_op(op_b), .req_addr(addr_b), .req_wdata(wd_b),
    .busy(busy_b), .done(done_b), .err(err_b), .rdata(rd_b),
    .ready(ready_b), .addr_wide(wide_b), .sum_bad(bad_b), .station(st_b));
  eeprom_model #(.AWM(8)) i_mdl_b (.cs(cs_b), .sclk(sclk_b), .di(di_b), .dout(do_b));

  int checks = 0;
  int errors = 0;
  logic [15:0] wa [0:63];
  logic [15:0] wb [0:255];

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Scoreboard: {check_data, err, data} plus a tag per expected completion
  logic [17:0] exp_q [$];
  string       tag_q [$];

  always @(negedge clk) begin
    if (rst_n && done_a) begin
      if (exp_q.size() == 0) check(1'b0, "R12 unexpected done", 1, 0);
      else begin
        logic [17:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(err_a == e[16], {t, " err"}, 64'(err_a), 64'(e[16]));
        if (e[17]) check(rd_a == e[15:0], {t, " data"}, 64'(rd_a), 64'(e[15:0]));
      end
    end
  end

  // R12: done never lasts two cycles
  logic done_prev = 0;
  always @(negedge clk) begin
    if (rst_n && done_a && done_prev) check(1'b0, "R12 done held", 1, 0);
    done_prev = done_a;
  end

  // Serial frame spy on A and minimum chip-select low time (R1, R8)
  logic [31:0] bits_cur = 0, bits_last = 0;
  int nb_cur = 0, nb_last = 0, cs_rises = 0, low_run = 0, low_min = 1000;
  always @(posedge sclk_a) if (cs_a) begin bits_cur = {bits_cur[30:0], di_a}; nb_cur++; end
  always @(posedge cs_a) begin bits_cur = 0; nb_cur = 0; cs_rises++; end
  always @(negedge cs_a) if (nb_cur > 0) begin bits_last = bits_cur; nb_last = nb_cur; end
  always @(posedge clk) begin
    if (!cs_a) low_run++;
    else begin
      if (low_run > 0 && cs_rises > 1 && low_run < low_min) low_min = low_run;
      low_run = 0;
    end
  end

  task automatic host(input logic [1:0] op, input logic [7:0] ad, input logic [15:0] wd,
                      input bit chk, input bit eerr, input logic [15:0] edata,
                      input string tag);
    @(negedge clk);
    while (busy_a) @(negedge clk);
    op_a = op; addr_a = ad; wd_a = wd; req_a = 1;
    exp_q.push_back({chk, eerr, edata});
    tag_q.push_back(tag);
    @(negedge clk);
    req_a = 0;
    while (busy_a) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    logic [15:0] s;
    logic [47:0] mac;
    int rises0;
    req_a = 0; op_a = 0; addr_a = 0; wd_a = 0;
    req_b = 0; op_b = 0; addr_b = 0; wd_b = 0;
    s = 0;
    for (int i = 0; i < 63; i++) begin
      wa[i] = 16'h1357 + 16'(i) * 16'h0203;
      s = s + wa[i];
    end
    wa[63] = 16'hBABA - s;
    for (int i = 0; i < 64; i++) i_mdl_a.mem[i] = wa[i];
    s = 16'hFFFF;
    wb[0] = 16'hFFFF;
    for (int i = 1; i < 63; i++) begin wb[i] = 16'(i) * 16'h0111; s = s + wb[i]; end
    wb[63] = 16'hBABA - s + 16'h0001;
    for (int i = 64; i < 256; i++) wb[i] = 16'(i) ^ 16'h5A00;
    wb[128] = 16'h8123;
    for (int i = 0; i < 256; i++) i_mdl_b.mem[i] = wb[i];

    repeat (3) @(negedge clk);
    check(busy_a == 1 && ready_a == 0 && done_a == 0, "R10 reset busy/ready",
          {ready_a, busy_a, done_a}, 3'b010);
    check(cs_a == 0 && sclk_a == 0, "R11 reset lines idle", {cs_a, sclk_a}, 0);
    rst_n = 1;
    @(negedge clk);
    while (!(ready_a && ready_b)) @(negedge clk);

    // Load results
    check(wide_a == 0, "R2 narrow device width", 64'(wide_a), 0);
    check(wide_b == 1, "R2 all-ones probe selects wide", 64'(wide_b), 1);
    mac = 0;
    for (int k = 0; k < 6; k++)
      mac = {mac[39:0], (k % 2 == 0) ? wa[k/2][7:0] : wa[k/2][15:8]};
    check(st_a == mac && bad_a == 0, "R6 station from valid image", st_a, mac);
    check(st_b == 0 && bad_b == 1, "R7 corrupt image zeroes station",
          {bad_b, st_b}, {1'b1, 48'd0});

    // Reads
    host(2'b00, 8'd5, 0, 1, 0, wa[5], "R3 read word 5");
    check(nb_last == 25 && bits_last[24:16] == {3'b110, 6'd5}, "R1 read frame",
          {nb_last[7:0], bits_last[24:16]}, {8'd25, 3'b110, 6'd5});
    host(2'b00, 8'd0, 0, 1, 0, wa[0], "R3 read word 0");
    host(2'b00, 8'd63, 0, 1, 0, wa[63], "R3 read last word");
    host(2'b11, 8'd7, 0, 1, 0, wa[7], "R3 opcode 11 reads");

    // Write before enable is rejected with no bus activity
    rises0 = cs_rises;
    host(2'b01, 8'd10, 16'h1234, 0, 1, 0, "R9 write before enable");
    check(cs_rises == rises0, "R9 no chip select activity", 64'(cs_rises - rises0), 0);
    host(2'b00, 8'd10, 0, 1, 0, wa[10], "R9 word unchanged");

    // Enable, then write and read back
    host(2'b10, 8'd0, 0, 0, 0, 0, "R1 write-enable");
    check(nb_last == 9 && bits_last[8:0] == 9'b100_111111, "R1 enable frame",
          {nb_last[7:0], bits_last[8:0]}, {8'd9, 9'b100111111});
    host(2'b01, 8'd10, 16'hA5C3, 0, 0, 0, "R4 write completes");
    check(nb_last == 25 && bits_last[15:0] == 16'hA5C3, "R4 write data bits",
          {nb_last[7:0], bits_last[15:0]}, {8'd25, 16'hA5C3});
    host(2'b00, 8'd10, 0, 1, 0, 16'hA5C3, "R4 read back");

    // Request during busy is ignored
    @(negedge clk);
    op_a = 2'b00; addr_a = 8'd11; req_a = 1;
    exp_q.push_back({1'b1, 1'b0, wa[11]});
    tag_q.push_back("R10 accepted read");
    @(negedge clk);
    req_a = 0;
    repeat (4) @(negedge clk);
    op_a = 2'b01; addr_a = 8'd11; wd_a = 16'h0000; req_a = 1;
    @(negedge clk);
    req_a = 0;
    while (busy_a) @(negedge clk);
    repeat (3) @(negedge clk);
    host(2'b00, 8'd11, 0, 1, 0, wa[11], "R10 busy request ignored");

    // Programming never finishes: timeout
    i_mdl_a.stuck = 1;
    host(2'b01, 8'd12, 16'h0F0F, 0, 1, 0, "R5 write timeout");
    i_mdl_a.stuck = 0;

    check(low_min >= DIV, "R8 chip select gap", 64'(low_min), 64'(DIV));
    check(exp_q.size() == 0, "R12 one done per request", 64'(exp_q.size()), 0);

    // Wide device addressing above word 63
    @(negedge clk);
    op_b = 2'b00; addr_b = 8'h80; req_b = 1;
    @(negedge clk);
    req_b = 0;
    while (!done_b) @(negedge clk);
    check(rd_b == 16'h8123 && err_b == 0, "R2 8-bit address read", 64'(rd_b), 64'h8123);

    summary();
  end
endmodule